// File: doc/BRIEF.md
# Cache Maintenance Command Sequencer

This block is the control side of a small two-way set-associative cache. Software writes a three-bit command. The block then turns the cache on or off, or it runs a cache-wide maintenance sweep. A sweep either clears every valid flag or clears every lock flag. It handles one set index per clock, and a busy flag stays high for the whole sweep. A three-bit status word reports the enable state, the busy state and a sticky error flag for unknown commands.

The valid, lock, tag and replacement flags are held in small internal arrays. A fill port loads a way, and a lookup port reports hits. A read port exposes the stored contents of any entry, so they can still be inspected after a reset. A reset turns the cache off and clears the control state, but it leaves the array contents untouched.

Top module: `cache_ctl_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `status` reads 0: the enable bit (bit 0) is off, the busy bit (bit 1) is low and the error bit (bit 2) is clear.
- R2: Reset does not modify any stored valid, lock, tag or replacement bit. `rd_*` returns the same contents before and after reset.
- R3: The command 3'b001 sets the enable bit and the command 3'b010 clears it. Both take effect in the cycle after the write.
- R4: The command 3'b110 clears the valid flag of both ways in every set. It also sets every set's replacement bit to 0, so that it points to way 0.
- R5: The command 3'b101 clears the lock flag of both ways in every set. It leaves the valid flags, the tags and the replacement bits unchanged.
- R6: After a 3'b101 or 3'b110 write, the busy bit is high for exactly SETS cycles, starting the cycle after the write, and one set is processed per cycle. Command writes made while busy is high are ignored and do not set the error bit.
- R7: Any command other than 001, 010, 101 or 110 changes nothing else. It sets the error bit, and the bit stays set until reset.
- R8: `lk_hit` is 1 only when the cache is enabled, no sweep is running, and a valid way at `lk_idx` holds `lk_tag`. `lk_way` names the hitting way, and way 0 wins if both ways hit. It is 0 when there is no hit.
- R9: In a cycle with no sweep running, a lookup with `lk_en` that hits way w sets that set's replacement bit to the other way. A fill of way w does the same, and a fill takes priority over a lookup in the same cycle.
- R10: A fill writes valid=1, the tag and the lock flag into the given way. It is refused if that way is currently both valid and locked. It is also ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cmd_wr | input | 1 | Command write strobe |
| cmd | input | 3 | Command code |
| status | output | 3 | {error, busy, enable} |
| fill_en | input | 1 | Fill strobe |
| fill_idx | input | IW | Set index to fill |
| fill_way | input | 1 | Way to fill |
| fill_tag | input | TAG_W | Tag to store |
| fill_lock | input | 1 | Lock flag to store |
| lk_en | input | 1 | Lookup qualifies a replacement update |
| lk_idx | input | IW | Lookup set index |
| lk_tag | input | TAG_W | Lookup tag |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Way that hit |
| rd_idx | input | IW | Inspection set index |
| rd_way | input | 1 | Inspection way |
| rd_valid | output | 1 | Stored valid flag |
| rd_lock | output | 1 | Stored lock flag |
| rd_tag | output | TAG_W | Stored tag |
| rd_lru | output | 1 | Replacement bit of the set |

## Verification
A wrong sweep counter or an early end of a sweep shows up on the busy bit. It appears in the very cycle where the busy-high window is too short or too long. A set the sweep missed appears later as a stale valid or lock flag on the inspection port. A lost enable bit, or a valid flag that was not cleared, turns into a wrong `lk_hit` on the next lookup of that set. The bench compares every port against a behavioural model on every clock, so any difference is reported within one cycle of the first point where it can be observed.

// File: rtl/cache_ctl_seq.sv
module cache_ctl_seq #(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int IW = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [2:0]       cmd,
  output logic [2:0]       status,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_lock,
  input  logic             lk_en,
  input  logic [IW-1:0]    lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             lk_way,
  input  logic [IW-1:0]    rd_idx,
  input  logic             rd_way,
  output logic             rd_valid,
  output logic             rd_lock,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_lru
);
  localparam logic [2:0] C_ENABLE = 3'b001, C_DISABLE = 3'b010,
                         C_UNLOCK = 3'b101, C_INVAL   = 3'b110;

  logic [SETS-1:0]  vld [2];
  logic [SETS-1:0]  lck [2];
  logic [TAG_W-1:0] tag [2][SETS];
  logic [SETS-1:0]  lru;

  logic          en, busy, err, inval_mode;
  logic [IW-1:0] ptr;

  assign status = {err, busy, en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      busy <= 1'b0;
      err <= 1'b0;
      inval_mode <= 1'b0;
      ptr <= '0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == IW'(SETS - 1)) busy <= 1'b0;
    end else if (cmd_wr) begin
      case (cmd)
        C_ENABLE:  en <= 1'b1;
        C_DISABLE: en <= 1'b0;
        C_UNLOCK:  begin busy <= 1'b1; inval_mode <= 1'b0; ptr <= '0; end
        C_INVAL:   begin busy <= 1'b1; inval_mode <= 1'b1; ptr <= '0; end
        default:   err <= 1'b1;
      endcase
    end
  end

  logic hit0, hit1, fill_ok;
  assign hit0    = en && !busy && vld[0][lk_idx] && tag[0][lk_idx] == lk_tag;
  assign hit1    = en && !busy && vld[1][lk_idx] && tag[1][lk_idx] == lk_tag;
  assign lk_hit  = hit0 | hit1;
  assign lk_way  = !hit0 && hit1;
  assign fill_ok = fill_en && !busy && !(vld[fill_way][fill_idx] && lck[fill_way][fill_idx]);

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (busy) begin
        for (int w = 0; w < 2; w++) begin
          if (inval_mode) vld[w][ptr] <= 1'b0;
          else            lck[w][ptr] <= 1'b0;
        end
        if (inval_mode) lru[ptr] <= 1'b0;
      end else if (fill_ok) begin
        vld[fill_way][fill_idx] <= 1'b1;
        lck[fill_way][fill_idx] <= fill_lock;
        tag[fill_way][fill_idx] <= fill_tag;
        lru[fill_idx] <= !fill_way;
      end else if (lk_en && lk_hit) begin
        lru[lk_idx] <= !lk_way;
      end
    end
  end

  assign rd_valid = vld[rd_way][rd_idx];
  assign rd_lock  = lck[rd_way][rd_idx];
  assign rd_tag   = tag[rd_way][rd_idx];
  assign rd_lru   = lru[rd_idx];
endmodule

module cache_ctl_chk #(parameter int SETS = 16) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [2:0] cmd,
  input logic [2:0] status,
  input logic       lk_hit
);
  int unsigned run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else run <= status[1] ? run + 1 : 0;

  a_r6_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> run == SETS);
  a_r6_sweep_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cmd_wr && (cmd == 3'b101 || cmd == 3'b110)));
  a_r3_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !status[1] && cmd == 3'b001) |=> status[0]);
  a_r3_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !status[1] && cmd == 3'b010) |=> !status[0]);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |=> status[2]);
  a_r8_off_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] || status[1]) |-> !lk_hit);
endmodule

bind cache_ctl_seq cache_ctl_chk #(.SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd),
  .status(status), .lk_hit(lk_hit)
);

// File: tb/cache_ctl_seq_tb.sv
module cache_ctl_seq_tb;
  localparam int SETS = 16, TAG_W = 8, IW = $clog2(SETS);

  logic clk = 0, rst_n = 0, cmd_wr = 0, fill_en = 0, fill_way = 0, fill_lock = 0;
  logic lk_en = 0, rd_way = 0;
  logic [2:0] cmd = 0;
  logic [IW-1:0] fill_idx = 0, lk_idx = 0, rd_idx = 0;
  logic [TAG_W-1:0] fill_tag = 0, lk_tag = 0;
  logic [2:0] status;
  logic lk_hit, lk_way, rd_valid, rd_lock, rd_lru;
  logic [TAG_W-1:0] rd_tag;

  always #10 clk = ~clk;

  cache_ctl_seq #(.SETS(SETS), .TAG_W(TAG_W)) u_dut (.*);

  int errors = 0, checks = 0;
  bit armed = 0;

  bit mv [2][SETS], ml [2][SETS], mlru [SETS];
  int mt [2][SETS];
  bit men, mbusy, merr, minv;
  int mcnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mhit(input int w);
    return men && !mbusy && mv[w][lk_idx] && mt[w][lk_idx] == int'(lk_tag);
  endfunction

  task automatic compare();
    int es, eh, ew;
    es = rst_n ? {merr, mbusy, men} : 0;
    chk(status == 3'(es), "R1/R3/R6/R7 status", status, es);
    if (armed) begin
      eh = (mhit(0) || mhit(1)) && rst_n;
      ew = !mhit(0) && mhit(1) && rst_n;
      chk(lk_hit == eh, "R8 lk_hit", lk_hit, eh);
      chk(lk_way == ew, "R8 lk_way", lk_way, ew);
      chk(rd_valid == mv[rd_way][rd_idx], "R2/R4 rd_valid", rd_valid, mv[rd_way][rd_idx]);
      chk(rd_lock == ml[rd_way][rd_idx], "R5 rd_lock", rd_lock, ml[rd_way][rd_idx]);
      chk(rd_lru == mlru[rd_idx], "R9 rd_lru", rd_lru, mlru[rd_idx]);
      if (mv[rd_way][rd_idx])
        chk(int'(rd_tag) == mt[rd_way][rd_idx], "R10 rd_tag", rd_tag, mt[rd_way][rd_idx]);
    end
  endtask

  task automatic model_step();
    bit was_busy, h0, h1;
    if (!rst_n) begin
      men = 0; mbusy = 0; merr = 0;
      return;
    end
    was_busy = mbusy;
    h0 = mhit(0); h1 = mhit(1);
    if (was_busy) begin
      for (int w = 0; w < 2; w++) if (minv) mv[w][mcnt] = 0; else ml[w][mcnt] = 0;
      if (minv) mlru[mcnt] = 0;
      mcnt++;
      if (mcnt == SETS) mbusy = 0;
    end else begin
      if (cmd_wr) begin
        if (cmd == 3'b001) men = 1;
        else if (cmd == 3'b010) men = 0;
        else if (cmd == 3'b101 || cmd == 3'b110) begin mbusy = 1; minv = (cmd == 3'b110); mcnt = 0; end
        else merr = 1;
      end
      if (fill_en && !(mv[fill_way][fill_idx] && ml[fill_way][fill_idx])) begin
        mv[fill_way][fill_idx] = 1; ml[fill_way][fill_idx] = fill_lock;
        mt[fill_way][fill_idx] = int'(fill_tag); mlru[fill_idx] = !fill_way;
      end else if (lk_en && (h0 || h1)) mlru[lk_idx] = h0 ? 1'b1 : 1'b0;
    end
  endtask

  task automatic step();
    #5 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmd_wr = 0; fill_en = 0; lk_en = 0;
  endtask

  task automatic command(input logic [2:0] c);
    cmd = c; cmd_wr = 1; step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin rd_idx = IW'(i); rd_way = i[0]; step(); end
  endtask

  task automatic fill(input int idx, input bit w, input int t, input bit lk);
    fill_idx = IW'(idx); fill_way = w; fill_tag = TAG_W'(t); fill_lock = lk; fill_en = 1;
    rd_idx = IW'(idx); rd_way = w; step();
    step();
  endtask

  task automatic look(input int idx, input int t, input bit en);
    lk_idx = IW'(idx); lk_tag = TAG_W'(t); lk_en = en; rd_idx = IW'(idx); step();
    step();
  endtask

  task automatic dump_all();
    for (int i = 0; i < 2 * SETS; i++) begin rd_idx = IW'(i / 2); rd_way = i[0]; step(); end
  endtask

  initial begin
    @(negedge clk);
    step(); step();
    chk(status == 0, "R1 status in reset", status, 0);
    rst_n = 1; step();
    command(3'b110); idle(SETS + 1);
    command(3'b101); idle(SETS + 1);
    armed = 1;
    dump_all();
    command(3'b001);
    chk(status[0] == 1, "R3 enable", status[0], 1);
    fill(3, 0, 8'h3A, 0); fill(3, 1, 8'h3B, 1); fill(7, 1, 8'h77, 0); fill(9, 0, 8'h99, 1);
    look(3, 8'h3A, 1); look(3, 8'h3B, 1); look(7, 8'h77, 1); look(7, 8'h12, 1);
    look(9, 8'h99, 0);
    fill(3, 1, 8'hEE, 0);
    chk(rd_tag == 8'h3B, "R10 locked way kept", rd_tag, 8'h3B);
    fill(3, 0, 8'h55, 1);
    command(3'b011);
    chk(status[2] == 1, "R7 error set", status[2], 1);
    command(3'b111); command(3'b000); command(3'b100);
    chk(status[0] == 1, "R7 enable unchanged", status[0], 1);
    command(3'b010);
    look(3, 8'h55, 1);
    chk(lk_hit == 0, "R8 disabled miss", lk_hit, 0);
    command(3'b001);
    command(3'b101);
    command(3'b010); command(3'b011);
    fill(5, 0, 8'h5C, 0);
    look(7, 8'h77, 1);
    idle(SETS);
    chk(status == 3'b101, "R6 busy ignored cmds", status, 3'b101);
    dump_all();
    fill(9, 0, 8'hA9, 1);
    rst_n = 0; step(); step(); rst_n = 1; step();
    chk(status == 0, "R1 after reset", status, 0);
    dump_all();
    command(3'b001); look(9, 8'hA9, 1);
    chk(lk_hit == 1, "R2 contents survive reset", lk_hit, 1);
    command(3'b110); idle(SETS + 2);
    dump_all();
    look(9, 8'hA9, 1);
    chk(lk_hit == 0, "R4 invalidated miss", lk_hit, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule